// File: doc/BRIEF.md
# Cold reset release sequencer

This block brings a serial-link controller out of cold reset. After a start command it releases the controller's reset domains one at a time in a fixed order. It waits where the power manager still asks for a domain to be held, and it turns on the application and reference clock enables partway through. The application-side reset gets a short pulse rather than a held level. The endpoint reset is released last, and a settle interval follows before the block reports done. The power manager's two hold requests arrive as plain level inputs. The clock generators are downstream of the two enable outputs.

Each hold-request wait samples the flag once every poll interval and gives up after a timeout. On timeout the sequencer undoes its completed steps one per cycle, in the reverse of the order it took them. It then reports an error with every domain held and both clocks off. A stop command works from any state. It holds every domain, drops both clock enables and the training enable, and stays busy for a long settle delay. All intervals are cycle-count parameters.

Top module: `rseq_cold_release`

## Requirements
- R1: After reset every reset output is 1 (held), both clock enables, app_rst_o, train_en_o, busy_o, done_o and err_o are 0.
- R2: After an accepted start, power reset is released first, hot reset after it, and PHY reset after hot reset.
- R3: PHY reset is released only after a poll, taken every POLL_CYC cycles while waiting, sees pm_phy_req_i at 0; the release appears at most POLL_CYC+2 cycles after the later of the flag clearing and the hot-reset release.
- R4: The application clock enable rises after PHY release, the reference clock enable after it, and both before PIPE reset is released.
- R5: PIPE reset and then core reset are released only after a poll sees pm_core_req_i at 0, with the same poll bound as R3 measured from the reference clock enable.
- R6: After core release, app_rst_o is 1 for exactly PULSE_CYC cycles and then returns to 0; it is 1 at no other time.
- R7: Sticky, non-sticky and endpoint resets are released in that order after the pulse ends, and done_o rises exactly SETTLE_CYC cycles after the endpoint release.
- R8: If a flag is still 1 after TMO_CYC cycles of waiting, the first undo step shows TMO_CYC+1 cycles after the wait began. The remaining undo steps follow one per cycle in reverse order (reference clock, application clock, PHY, hot, power). err_o rises the cycle after power reset is held again, and done_o stays 0.
- R9: One cycle after stop_i, every reset is held, both clock enables, train_en_o, app_rst_o, done_o and err_o are 0. busy_o then stays 1 for exactly STOP_CYC cycles.
- R10: start_i is accepted only while idle (not busy and not done): a start during stop or in the done state changes no output. done_o and err_o are never 1 together.
- R11: train_en_o is 1 exactly when done_o is 1 and train_req_i was 1 at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start the release sequence (idle only) |
| stop_i | input | 1 | Stop: hold everything, then long settle |
| pm_phy_req_i | input | 1 | Power manager asks PHY reset to stay held |
| pm_core_req_i | input | 1 | Power manager asks core reset to stay held |
| train_req_i | input | 1 | Request to enable link training |
| pwr_rst_o | output | 1 | Power reset, 1 = held |
| hot_rst_o | output | 1 | Hot reset, 1 = held |
| phy_rst_o | output | 1 | PHY reset, 1 = held |
| pipe_rst_o | output | 1 | PIPE interface reset, 1 = held |
| core_rst_o | output | 1 | Controller core reset, 1 = held |
| app_rst_o | output | 1 | Application reset pulse |
| sticky_rst_o | output | 1 | Sticky register reset, 1 = held |
| nsticky_rst_o | output | 1 | Non-sticky register reset, 1 = held |
| ep_rst_o | output | 1 | Endpoint reset, 1 = held |
| app_clk_en_o | output | 1 | Application clock enable |
| ref_clk_en_o | output | 1 | Reference clock enable |
| train_en_o | output | 1 | Link training enable |
| busy_o | output | 1 | Sequence or stop delay in progress |
| done_o | output | 1 | Release sequence complete |
| err_o | output | 1 | Wait timed out and was undone |

## Verification
The bench builds the block with POLL_CYC=4, TMO_CYC=40, PULSE_CYC=3, SETTLE_CYC=10 and STOP_CYC=30. With these values a full start-and-stop round is under a hundred cycles. The bench can therefore sweep every pair of flag-clear delays from 0 to 9 cycles and check the poll bounds for each. The short timeout also brings both undo paths within reach, one for each wait. The bench checks the exact timeout cycle and the one-step-per-cycle unwind on each path.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  localparam int STAGE_W = 4;
  typedef logic [STAGE_W-1:0] stage_t;

  // Held lines, indexed: 0 power, 1 hot, 2 phy, 3 pipe, 4 core,
  // 5 sticky, 6 non-sticky, 7 endpoint. Line i is released once the
  // completed-step count reaches REL_AT[i].
  localparam int N_HOLD = 8;
  localparam stage_t REL_AT [N_HOLD] = '{4'd1, 4'd2, 4'd3, 4'd6, 4'd7, 4'd9, 4'd10, 4'd11};

  // Clock enables: 0 application, 1 reference.
  localparam int N_CLK = 2;
  localparam stage_t CLK_AT [N_CLK] = '{4'd4, 4'd5};

  localparam stage_t STG_PHY_WAIT  = 4'd2;
  localparam stage_t STG_CORE_WAIT = 4'd5;
  localparam stage_t STG_PULSE     = 4'd7;
  localparam stage_t STG_PRE_LAST  = 4'd10;
  localparam stage_t STG_LAST      = 4'd11;

  typedef enum logic [2:0] {
    S_IDLE, S_RUN, S_PULSE, S_SETTLE, S_DONE, S_UNWIND, S_STOP
  } seq_state_t;
endpackage

// File: rtl/rseq_stage_decode.sv
module rseq_stage_decode
  import rseq_pkg::*;
(
  input  stage_t              stage_i,
  output logic [N_HOLD-1:0]   hold_o,
  output logic [N_CLK-1:0]    clk_en_o
);
  for (genvar i = 0; i < N_HOLD; i++) begin : g_hold
    assign hold_o[i] = (stage_i < REL_AT[i]);
  end

  for (genvar j = 0; j < N_CLK; j++) begin : g_clk
    assign clk_en_o[j] = (stage_i >= CLK_AT[j]);
  end
endmodule

// File: rtl/rseq_flag_poll.sv
module rseq_flag_poll #(
  parameter int POLL_CYC = 125,
  parameter int TMO_CYC  = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic flag_i,
  output logic ok_o,
  output logic tmo_o
);
  localparam int PW = $clog2(POLL_CYC + 1);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic [PW-1:0] pcnt;
  logic [TW-1:0] tcnt;
  logic tick, limit;

  assign tick  = (pcnt == PW'(POLL_CYC - 1));
  assign limit = (tcnt == TW'(TMO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      tcnt <= '0;
    end else if (!en_i) begin
      pcnt <= '0;
      tcnt <= '0;
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (!limit) tcnt <= tcnt + 1'b1;
    end
  end

  assign ok_o  = en_i && tick && !flag_i;
  assign tmo_o = en_i && limit && !ok_o;

  // R8: a timeout is only ever raised while the request flag is still set
  a_r8_tmo_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> flag_i);
endmodule

// File: rtl/rseq_delay.sv
module rseq_delay #(
  parameter int MAX_CYC = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic [$clog2(MAX_CYC+1)-1:0] val_i,
  output logic                        zero_o
);
  localparam int CW = $clog2(MAX_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load_i)     cnt <= val_i;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/rseq_cold_release.sv
module rseq_cold_release
  import rseq_pkg::*;
#(
  parameter int POLL_CYC   = 125,
  parameter int TMO_CYC    = 125000,
  parameter int PULSE_CYC  = 4,
  parameter int SETTLE_CYC = 12500,
  parameter int STOP_CYC   = 12500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic pm_phy_req_i,
  input  logic pm_core_req_i,
  input  logic train_req_i,
  output logic pwr_rst_o,
  output logic hot_rst_o,
  output logic phy_rst_o,
  output logic pipe_rst_o,
  output logic core_rst_o,
  output logic app_rst_o,
  output logic sticky_rst_o,
  output logic nsticky_rst_o,
  output logic ep_rst_o,
  output logic app_clk_en_o,
  output logic ref_clk_en_o,
  output logic train_en_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  localparam int MAX_A = (STOP_CYC > SETTLE_CYC) ? STOP_CYC : SETTLE_CYC;
  localparam int TMAX  = (MAX_A > PULSE_CYC) ? MAX_A : PULSE_CYC;
  localparam int TW    = $clog2(TMAX + 1);

  seq_state_t st, st_n;
  stage_t     stg, stg_n;
  logic       err_q, err_n, done_q, train_q;
  logic       ld;
  logic [TW-1:0] ld_val;
  logic       t_zero;
  logic       p_en, p_flag, p_ok, p_tmo;
  logic [N_HOLD-1:0] hold;
  logic [N_CLK-1:0]  clk_en;

  assign p_en   = (st == S_RUN) && ((stg == STG_PHY_WAIT) || (stg == STG_CORE_WAIT));
  assign p_flag = (stg == STG_PHY_WAIT) ? pm_phy_req_i : pm_core_req_i;

  rseq_flag_poll #(.POLL_CYC(POLL_CYC), .TMO_CYC(TMO_CYC)) u_poll (
    .clk(clk), .rst_n(rst_n), .en_i(p_en), .flag_i(p_flag),
    .ok_o(p_ok), .tmo_o(p_tmo)
  );

  rseq_delay #(.MAX_CYC(TMAX)) u_delay (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .val_i(ld_val), .zero_o(t_zero)
  );

  rseq_stage_decode u_dec (.stage_i(stg), .hold_o(hold), .clk_en_o(clk_en));

  always_comb begin
    st_n   = st;
    stg_n  = stg;
    err_n  = err_q;
    ld     = 1'b0;
    ld_val = '0;
    if (stop_i) begin
      st_n   = S_STOP;
      stg_n  = '0;
      err_n  = 1'b0;
      ld     = 1'b1;
      ld_val = TW'(STOP_CYC - 1);
    end else begin
      unique case (st)
        S_IDLE: if (start_i) begin
          st_n  = S_RUN;
          err_n = 1'b0;
        end
        S_RUN: begin
          if ((stg == STG_PHY_WAIT) || (stg == STG_CORE_WAIT)) begin
            if (p_ok)       stg_n = stage_t'(stg + 1'b1);
            else if (p_tmo) st_n  = S_UNWIND;
          end else if (stg == STG_PULSE) begin
            st_n   = S_PULSE;
            ld     = 1'b1;
            ld_val = TW'(PULSE_CYC - 1);
          end else if (stg == STG_PRE_LAST) begin
            stg_n  = STG_LAST;
            st_n   = S_SETTLE;
            ld     = 1'b1;
            ld_val = TW'(SETTLE_CYC - 1);
          end else begin
            stg_n = stage_t'(stg + 1'b1);
          end
        end
        S_PULSE: if (t_zero) begin
          stg_n = stage_t'(stg + 1'b1);
          st_n  = S_RUN;
        end
        S_SETTLE: if (t_zero) st_n = S_DONE;
        S_DONE:   st_n = S_DONE;
        S_UNWIND: begin
          if (stg == '0) begin
            st_n  = S_IDLE;
            err_n = 1'b1;
          end else begin
            stg_n = stage_t'(stg - 1'b1);
          end
        end
        S_STOP: if (t_zero) st_n = S_IDLE;
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      stg     <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      train_q <= 1'b0;
    end else begin
      st      <= st_n;
      stg     <= stg_n;
      err_q   <= err_n;
      done_q  <= (st_n == S_DONE);
      train_q <= (st_n == S_DONE) && train_req_i;
    end
  end

  assign pwr_rst_o     = hold[0];
  assign hot_rst_o     = hold[1];
  assign phy_rst_o     = hold[2];
  assign pipe_rst_o    = hold[3];
  assign core_rst_o    = hold[4];
  assign sticky_rst_o  = hold[5];
  assign nsticky_rst_o = hold[6];
  assign ep_rst_o      = hold[7];
  assign app_clk_en_o  = clk_en[0];
  assign ref_clk_en_o  = clk_en[1];
  assign app_rst_o     = (st == S_PULSE);
  assign train_en_o    = train_q;
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign busy_o        = (st != S_IDLE) && (st != S_DONE);

  // R2: hot reset never released while power reset is held
  a_r2_hot_after_pwr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hot_rst_o) |-> !pwr_rst_o);
  // R3: PHY release follows a sample of the PHY request flag at zero
  a_r3_phy_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_rst_o) |-> !$past(pm_phy_req_i));
  // R4: reference clock comes on only with the application clock on
  a_r4_ref_after_app: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_clk_en_o) |-> (app_clk_en_o && !phy_rst_o));
  // R5: PIPE release follows a sample of the core request flag at zero
  a_r5_pipe_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pipe_rst_o) |-> !$past(pm_core_req_i));
  // R6: application pulse only with core running and sticky still held
  a_r6_pulse_window: assert property (@(posedge clk) disable iff (!rst_n)
    app_rst_o |-> (!core_rst_o && sticky_rst_o));
  // R7: endpoint released only after non-sticky
  a_r7_ep_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ep_rst_o) |-> !nsticky_rst_o);
  // R9: stop holds everything on the next cycle
  a_r9_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (pwr_rst_o && ep_rst_o && !app_clk_en_o && !ref_clk_en_o && !train_en_o));
  // R10: done and error are exclusive
  a_r10_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
endmodule

// File: tb/tb_rseq_cold_release.sv
`timescale 1ns/1ps
module tb_rseq_cold_release;
  localparam int P_POLL = 4, P_TMO = 40, P_PULSE = 3, P_SET = 10, P_STOP = 30;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start_i, stop_i, pm_phy, pm_core, train_req;
  logic pwr, hot, phy, pipe, core, app_rst, sticky, nsticky, ep;
  logic aclk, rclk, train_en, busy, done, err;

  rseq_cold_release #(.POLL_CYC(P_POLL), .TMO_CYC(P_TMO), .PULSE_CYC(P_PULSE),
                      .SETTLE_CYC(P_SET), .STOP_CYC(P_STOP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .pm_phy_req_i(pm_phy), .pm_core_req_i(pm_core), .train_req_i(train_req),
    .pwr_rst_o(pwr), .hot_rst_o(hot), .phy_rst_o(phy), .pipe_rst_o(pipe),
    .core_rst_o(core), .app_rst_o(app_rst), .sticky_rst_o(sticky),
    .nsticky_rst_o(nsticky), .ep_rst_o(ep), .app_clk_en_o(aclk),
    .ref_clk_en_o(rclk), .train_en_o(train_en), .busy_o(busy),
    .done_o(done), .err_o(err)
  );

  int errs = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] holds();
    return {ep, nsticky, sticky, core, pipe, phy, hot, pwr};
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  // fail_mode: 0 none, 1 PHY wait times out, 2 core wait times out
  task automatic run_seq(input int pd, input int cd, input int fail_mode);
    int t_rel[8]; int t_reh[8]; int t_on[2]; int t_off[2];
    int t_ar, t_af, t_done, t_err, app_hi;
    bit bad_excl, bad_train;
    logic [7:0] ph, h; logic [1:0] pc, ck;
    logic pa;
    for (int i = 0; i < 8; i++) begin t_rel[i] = -1; t_reh[i] = -1; end
    for (int i = 0; i < 2; i++) begin t_on[i] = -1; t_off[i] = -1; end
    t_ar = -1; t_af = -1; t_done = -1; t_err = -1; app_hi = 0;
    bad_excl = 0; bad_train = 0;
    ph = 8'hFF; pc = 2'b00; pa = 1'b0;
    pm_phy = 1'b1; pm_core = 1'b1; train_req = 1'b1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int c = 0; c < 400; c++) begin
      pm_phy  = (pd < 0) || (c < pd);
      pm_core = (cd < 0) || (c < cd);
      h  = holds();
      ck = {rclk, aclk};
      for (int i = 0; i < 8; i++) begin
        if (ph[i] && !h[i] && t_rel[i] < 0) t_rel[i] = c;
        if (!ph[i] && h[i] && t_reh[i] < 0) t_reh[i] = c;
      end
      for (int i = 0; i < 2; i++) begin
        if (!pc[i] && ck[i] && t_on[i] < 0) t_on[i] = c;
        if (pc[i] && !ck[i] && t_off[i] < 0) t_off[i] = c;
      end
      if (!pa && app_rst) t_ar = c;
      if (pa && !app_rst) t_af = c;
      if (app_rst) app_hi++;
      if (done && err) bad_excl = 1;
      if (train_en !== done) bad_train = 1;
      ph = h; pc = ck; pa = app_rst;
      if (done) begin t_done = c; break; end
      if (err)  begin t_err = c; break; end
      @(negedge clk);
    end
    chk(!bad_excl, "R10", "done and err together", bad_excl, 0);
    chk(!bad_train, "R11", "train_en tracks done with request held", bad_train, 0);
    if (fail_mode == 0) begin
      chk(t_done >= 0 && t_err < 0, "R7", "sequence reached done", t_done >= 0, 1);
      chk(t_rel[0] >= 0 && t_rel[1] > t_rel[0] && t_rel[2] > t_rel[1], "R2",
          "pwr/hot/phy order", t_rel[1], t_rel[0] + 1);
      chk(t_rel[2] >= pd + 1 && t_rel[2] <= imax(pd, t_rel[1]) + P_POLL + 2, "R3",
          "phy release cycle", t_rel[2], imax(pd, t_rel[1]) + P_POLL);
      chk(t_on[0] > t_rel[2] && t_on[1] > t_on[0] && t_rel[3] > t_on[1], "R4",
          "clock enable order", t_on[1], t_on[0] + 1);
      chk(t_rel[3] >= cd + 1 && t_rel[3] <= imax(cd, t_on[1]) + P_POLL + 2 &&
          t_rel[4] > t_rel[3], "R5", "pipe release cycle", t_rel[3],
          imax(cd, t_on[1]) + P_POLL);
      chk(t_ar > t_rel[4] && t_af - t_ar == P_PULSE && app_hi == P_PULSE, "R6",
          "app reset pulse width", app_hi, P_PULSE);
      chk(t_rel[5] >= t_af && t_rel[6] > t_rel[5] && t_rel[7] > t_rel[6], "R7",
          "sticky/nsticky/endpoint order", t_rel[7], t_rel[6] + 1);
      chk(t_done - t_rel[7] == P_SET, "R7", "settle length", t_done - t_rel[7], P_SET);
    end else begin
      chk(t_err >= 0 && t_done < 0, "R8", "error reported", t_err >= 0, 1);
      chk(holds() == 8'hFF && !aclk && !rclk, "R8", "all held after unwind",
          int'(holds()), 255);
      if (fail_mode == 1) begin
        chk(t_reh[1] - t_rel[1] == P_TMO + 1, "R8", "phy wait timeout", t_reh[1] - t_rel[1],
            P_TMO + 1);
        chk(t_reh[0] == t_reh[1] + 1 && t_err == t_reh[0] + 1 && t_on[0] < 0, "R8",
            "phy unwind order", t_reh[0], t_reh[1] + 1);
      end else begin
        chk(t_off[1] - t_on[1] == P_TMO + 1, "R8", "core wait timeout", t_off[1] - t_on[1],
            P_TMO + 1);
        chk(t_off[0] == t_off[1] + 1 && t_reh[2] == t_off[0] + 1 && t_reh[1] == t_reh[2] + 1 &&
            t_reh[0] == t_reh[1] + 1 && t_err == t_reh[0] + 1, "R8", "core unwind order",
            t_reh[0], t_off[1] + 4);
      end
    end
  endtask

  task automatic do_stop(input bit poke_start);
    int n;
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    chk(holds() == 8'hFF && !aclk && !rclk && !train_en && !app_rst && !done && !err,
        "R9", "stop holds all", int'(holds()), 255);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (poke_start && n == 5) start_i = 1'b1;
      else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(n == P_STOP, "R9", "stop busy length", n, P_STOP);
    if (poke_start) begin
      repeat (4) @(negedge clk);
      chk(!busy && pwr && holds() == 8'hFF, "R10", "start during stop ignored", busy, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0;
    pm_phy = 1'b1; pm_core = 1'b1; train_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(holds() == 8'hFF && !aclk && !rclk && !app_rst && !train_en && !busy && !done && !err,
        "R1", "reset state", int'(holds()), 255);
    rst_n = 1'b1;
    @(negedge clk);
    chk(holds() == 8'hFF && !busy, "R1", "idle after reset", busy, 0);

    do_stop(1'b1);

    // Done state: start ignored, training follows its request
    run_seq(2, 3, 0);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(done && !busy && !ep, "R10", "start in done ignored", busy, 0);
    train_req = 1'b0; @(negedge clk);
    chk(!train_en, "R11", "train_en drops with request", train_en, 0);
    train_req = 1'b1; @(negedge clk);
    chk(train_en, "R11", "train_en follows request", train_en, 1);
    do_stop(1'b0);

    // Timeout paths
    run_seq(-1, 0, 1);
    do_stop(1'b0);
    run_seq(0, -1, 2);
    do_stop(1'b0);

    // Sweep of flag-clear delays
    for (int pd = 0; pd < 10; pd++) begin
      for (int cd = 0; cd < 10; cd++) begin
        run_seq(pd, cd, 0);
        do_stop(1'b0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule